// File: doc/BRIEF.md
# Soft-start and hiccup fault sequencer

This block sequences the start-up of a voltage-mode buck regulator in the digital domain. The charge on the soft-start capacitor is held in an up/down counter whose code is a voltage in millivolt units. The counter moves by a fixed step once per prescaled tick, in the same way a constant current charges or discharges a capacitor along a linear slope. The counter produces three outputs: a ramped regulation reference for the error path, an enable for the gate drivers, and a flag that marks the end of soft-start.

The counter starts charging once the controller is enabled and both bias supplies report good. The reference stays at zero while the level is under the 1 V point. Above that point it follows one of two laws. In internal mode it scales linearly up to the 597 mV set point, which it reaches when the level is at 3 V. In external mode it rises one for one with the level until it meets an external code, and then it holds there. At the 4 V ceiling the done flag is set. An overcurrent event turns off the drivers and starts a hiccup cycle: the level charges to the ceiling if it is not already there, discharges along the same slope to zero, and then a normal ramp starts again.

Top module: `softstart_hiccup_seq`

## Requirements
- R1: After reset, ref_code, gate_en and ss_done are all 0.
- R2: Charging starts only when en is 1 and both sup_core_ok and sup_drv_ok are 1, in whichever order the two supplies arrive. While either supply is 0, gate_en and ref_code stay 0.
- R3: ref_code is 0 while the level is at or below V_LO_MV (1000 mV). With the defaults (STEP_MV=8, PRESCALE=4) the first nonzero ref_code appears about 504 cycles after gate_en rises.
- R4: When ref_sel_ext is 0, ref_code = (level-1000)*597/2000 for levels between 1000 and 3000 mV, and 597 above 3000 mV. It reaches 298 about 1000 cycles after gate_en rises and 597 about 1500 cycles after.
- R5: When ref_sel_ext is 1, ref_code = min(level-1000, ext_ref_code) and never exceeds ext_ref_code. With ext_ref_code=200 it reaches 200 about 600 cycles after gate_en rises.
- R6: The level rises by STEP_MV once every PRESCALE clocks and saturates at CEIL_MV (4000). Reaching the ceiling sets ss_done, about 2000 cycles after gate_en rises.
- R7: ss_done goes to 0 within two cycles of en falling, of either supply falling, or of an oc_evt pulse.
- R8: When en is 0, the level is cleared and gate_en and ref_code are 0 within two cycles. After en returns, the ramp starts again from zero.
- R9: An oc_evt while ss_done is 1 sets gate_en and ref_code to 0 and starts a discharge with the same slope as the charge. gate_en rises again about 2000 cycles later, when the level reaches zero.
- R10: An oc_evt during the ramp first lets the level charge to the ceiling and only then discharges it. An event 1000 cycles into the ramp gives a restart about 3000 cycles after the event.
- R11: An oc_evt that arrives while a fault is already being serviced has no effect on when the restart happens.
- R12: A disable while a fault is being serviced clears the fault. When en returns, the ramp starts at once from zero.
- R13: A fault that is present again at each restart repeats the charge-then-discharge cycle, so each hiccup period takes about 4000 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Controller enable; 0 shuts down and clears the level |
| sup_core_ok | input | 1 | Core bias supply good, already filtered |
| sup_drv_ok | input | 1 | Driver bias supply good, already filtered |
| oc_evt | input | 1 | Overcurrent event pulse |
| ref_sel_ext | input | 1 | 1 selects the external reference law |
| ext_ref_code | input | LVL_W | External reference value in mV |
| ref_code | output | LVL_W | Ramped regulation reference in mV |
| gate_en | output | 1 | Enable for both gate drivers |
| ss_done | output | 1 | Soft-start complete flag |

## Verification
The ramp is driven under both reference laws. Internal mode checks where the zero region ends, the midpoint, and the top of the scaling. External mode with a low target checks the one-for-one slope and the clamp, which tells an offset from a gain error. Overcurrent is injected at the ceiling, part way up the ramp, during a discharge, and again at every restart. The restart delays (2000, 3000, unchanged, 4000 cycles) tell apart an immediate discharge, charge-before-discharge, an event that is correctly ignored, and a repeating hiccup. Disable and supply loss are applied at the top of the ramp and in the middle of a fault, which shows that the level is cleared and that disable takes precedence.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_SUP,
    ST_RAMP,
    ST_DONE,
    ST_FLT_CHG,
    ST_FLT_DIS
  } ssq_state_t;
endpackage

// File: rtl/ssq_tick.sv
module ssq_tick #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_every
      always_ff @(posedge clk) begin
        if (rst) tick <= 1'b0;
        else     tick <= 1'b1;
      end
    end else begin : g_div
      localparam int CW = $clog2(PRESCALE);
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt  <= '0;
          tick <= 1'b0;
        end else begin
          tick <= (cnt == LAST);
          cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
      end
      // R6: ticks are spaced apart, never back to back
      p_tick_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
  import ssq_pkg::*;
#(
  parameter int LVL_W   = 12,
  parameter int STEP_MV = 8,
  parameter int CEIL_MV = 4000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             sup_ok,
  input  logic             oc_evt,
  output logic [LVL_W-1:0] level,
  output ssq_state_t       state,
  output logic             drv_en,
  output logic             ss_done
);
  localparam logic [LVL_W-1:0] CEIL_C = LVL_W'(CEIL_MV);
  localparam logic [LVL_W-1:0] STEP_C = LVL_W'(STEP_MV);

  ssq_state_t       nxt;
  logic [LVL_W-1:0] lvl_n, up, dn;

  always_comb begin
    up = (level > CEIL_C - STEP_C) ? CEIL_C : level + STEP_C;
    dn = (level < STEP_C) ? '0 : level - STEP_C;
  end

  always_comb begin
    nxt   = state;
    lvl_n = level;
    if (!en) begin
      nxt   = ST_OFF;
      lvl_n = '0;
    end else if (!sup_ok && state != ST_OFF) begin
      nxt   = ST_WAIT_SUP;
      lvl_n = '0;
    end else begin
      unique case (state)
        ST_OFF:      nxt = ST_WAIT_SUP;
        ST_WAIT_SUP: if (sup_ok) nxt = ST_RAMP;
        ST_RAMP: begin
          if (tick) lvl_n = up;
          if (oc_evt) nxt = ST_FLT_CHG;
          else if (tick && up == CEIL_C) nxt = ST_DONE;
        end
        ST_DONE:     if (oc_evt) nxt = ST_FLT_DIS;
        ST_FLT_CHG: begin
          if (tick) begin
            lvl_n = up;
            if (up == CEIL_C) nxt = ST_FLT_DIS;
          end
        end
        ST_FLT_DIS: begin
          if (tick) begin
            lvl_n = dn;
            if (dn == '0) nxt = ST_RAMP;
          end
        end
        default: begin
          nxt   = ST_OFF;
          lvl_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_OFF;
      level   <= '0;
      drv_en  <= 1'b0;
      ss_done <= 1'b0;
    end else begin
      state   <= nxt;
      level   <= lvl_n;
      drv_en  <= (nxt == ST_RAMP) || (nxt == ST_DONE);
      ss_done <= (nxt == ST_DONE);
    end
  end

  // R6: level never passes the ceiling
  p_level_cap_r6: assert property (@(posedge clk) disable iff (rst)
    level <= CEIL_C);
  // R8: disable clears the level and stops the drivers
  p_off_clear_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (level == '0 && !drv_en));
  // R2: no drive without both supplies
  p_supply_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !sup_ok |=> !drv_en);
  // R7: an overcurrent event drops the done flag
  p_done_drop_r7: assert property (@(posedge clk) disable iff (rst)
    oc_evt |=> !ss_done);
  // R9: the level never rises while discharging
  p_dis_falls_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FLT_DIS && $past(state) == ST_FLT_DIS) |-> level <= $past(level));
  // R11: a new event during discharge does not restart the charge phase
  p_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FLT_DIS && oc_evt && en && sup_ok) |=>
      (state == ST_FLT_DIS || state == ST_RAMP));
endmodule

// File: rtl/ssq_refgen.sv
module ssq_refgen #(
  parameter int LVL_W   = 12,
  parameter int V_LO_MV = 1000,
  parameter int V_HI_MV = 3000,
  parameter int INT_REF = 597
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LVL_W-1:0] level,
  input  logic             active,
  input  logic             ext_sel,
  input  logic [LVL_W-1:0] ext_ref,
  output logic [LVL_W-1:0] ref_code
);
  localparam int MW = LVL_W + $clog2(INT_REF + 1);
  localparam logic [LVL_W-1:0] LO_C   = LVL_W'(V_LO_MV);
  localparam logic [LVL_W-1:0] HI_C   = LVL_W'(V_HI_MV);
  localparam logic [LVL_W-1:0] INT_C  = LVL_W'(INT_REF);
  localparam logic [MW-1:0]    SPAN_C = MW'(V_HI_MV - V_LO_MV);

  logic [LVL_W-1:0] above, int_val, ext_val, calc;
  logic [MW-1:0]    prod;

  always_comb begin
    above   = (level > LO_C) ? level - LO_C : '0;
    prod    = MW'(above) * MW'(INT_REF);
    int_val = (level >= HI_C) ? INT_C : LVL_W'(prod / SPAN_C);
    ext_val = (above < ext_ref) ? above : ext_ref;
    calc    = ext_sel ? ext_val : int_val;
  end

  always_ff @(posedge clk) begin
    if (rst) ref_code <= '0;
    else     ref_code <= active ? calc : '0;
  end

  // R3: zero reference at or below the low threshold
  p_ref_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (level <= LO_C) |=> ref_code == '0);
  // R4: internal law never exceeds the set point
  p_int_cap_r4: assert property (@(posedge clk) disable iff (rst)
    !ext_sel |=> ref_code <= INT_C);
endmodule

// File: rtl/softstart_hiccup_seq.sv
module softstart_hiccup_seq
  import ssq_pkg::*;
#(
  parameter int LVL_W    = 12,
  parameter int PRESCALE = 4,
  parameter int STEP_MV  = 8,
  parameter int V_LO_MV  = 1000,
  parameter int V_HI_MV  = 3000,
  parameter int CEIL_MV  = 4000,
  parameter int INT_REF  = 597
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             sup_core_ok,
  input  logic             sup_drv_ok,
  input  logic             oc_evt,
  input  logic             ref_sel_ext,
  input  logic [LVL_W-1:0] ext_ref_code,
  output logic [LVL_W-1:0] ref_code,
  output logic             gate_en,
  output logic             ss_done
);
  logic             tick;
  logic [LVL_W-1:0] level;
  ssq_state_t       state;
  logic             active;

  ssq_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  ssq_ctrl #(.LVL_W(LVL_W), .STEP_MV(STEP_MV), .CEIL_MV(CEIL_MV)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .en(en),
    .sup_ok(sup_core_ok && sup_drv_ok), .oc_evt(oc_evt),
    .level(level), .state(state), .drv_en(gate_en), .ss_done(ss_done)
  );

  assign active = (state == ST_RAMP) || (state == ST_DONE);

  ssq_refgen #(.LVL_W(LVL_W), .V_LO_MV(V_LO_MV), .V_HI_MV(V_HI_MV),
               .INT_REF(INT_REF)) u_ref (
    .clk(clk), .rst(rst), .level(level), .active(active),
    .ext_sel(ref_sel_ext), .ext_ref(ext_ref_code), .ref_code(ref_code)
  );

  // R6: done only with the drivers running
  p_done_drive_r6: assert property (@(posedge clk) disable iff (rst)
    ss_done |-> gate_en);
  // R9: no reference while the drivers are off for two cycles
  p_ref_off_r9: assert property (@(posedge clk) disable iff (rst)
    (!gate_en && $past(!gate_en)) |-> ref_code == '0);
endmodule

// File: tb/sim_softstart_hiccup_seq.sv
module sim_softstart_hiccup_seq;
  logic clk = 1'b0, rst = 1'b1;
  logic en = 0, sup_core_ok = 0, sup_drv_ok = 0, oc_evt = 0, ref_sel_ext = 0;
  logic [11:0] ext_ref_code = '0;
  logic [11:0] ref_code;
  logic gate_en, ss_done;
  int checks = 0, fails = 0;
  localparam int TOL = 12;

  always #10 clk = ~clk;

  softstart_hiccup_seq u0 (
    .clk(clk), .rst(rst), .en(en), .sup_core_ok(sup_core_ok),
    .sup_drv_ok(sup_drv_ok), .oc_evt(oc_evt), .ref_sel_ext(ref_sel_ext),
    .ext_ref_code(ext_ref_code), .ref_code(ref_code), .gate_en(gate_en),
    .ss_done(ss_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic near(input string req, input int act, input int exp);
    chk((act >= exp - TOL) && (act <= exp + TOL), req, act, exp);
  endtask

  // kind 0: ref>=th, 1: done, 2: gate_en, 3: ref!=0
  task automatic meas(input int kind, input int th, input int maxc, output int n);
    n = 0;
    while (n < maxc) begin
      if (kind == 0 && ref_code >= 12'(th)) break;
      if (kind == 1 && ss_done) break;
      if (kind == 2 && gate_en) break;
      if (kind == 3 && ref_code != 0) break;
      @(negedge clk); n++;
    end
  endtask

  task automatic pulse_oc();
    oc_evt = 1; @(negedge clk); oc_evt = 0;
  endtask

  task automatic fresh_start();
    int n;
    en = 0; repeat (3) @(negedge clk);
    sup_core_ok = 1; sup_drv_ok = 1; en = 1;
    meas(2, 0, 20, n);
  endtask

  task automatic to_done();
    int n;
    fresh_start();
    meas(1, 0, 2100, n);
  endtask

  task automatic t_reset();
    chk(ref_code == 0 && !gate_en && !ss_done, "R1 reset outputs", {ref_code, gate_en, ss_done}, 0);
  endtask

  task automatic t_supply();
    int n;
    en = 1; sup_drv_ok = 1;
    repeat (600) @(negedge clk);
    chk(!gate_en && ref_code == 0, "R2 one supply only", {gate_en, ref_code}, 0);
    sup_core_ok = 1;
    meas(2, 0, 20, n);
    chk(n < 8, "R2 start after both supplies", n, 3);
  endtask

  task automatic t_ramp_int();
    int n;
    ref_sel_ext = 0;
    fresh_start();
    meas(3, 0, 2100, n); near("R3 zero below low threshold", n, 504);
    meas(0, 298, 2100, n); near("R4 midpoint time", n + 504, 1000);
    meas(0, 597, 2100, n); near("R4 set point time", n + 1000, 1500);
    meas(1, 0, 2100, n); near("R6 done at ceiling", n + 1500, 2000);
    chk(ref_code == 597, "R4 final value", ref_code, 597);
  endtask

  task automatic t_ramp_ext();
    int n, maxr;
    ref_sel_ext = 1; ext_ref_code = 200;
    fresh_start();
    meas(0, 200, 2100, n); near("R5 reach external", n, 600);
    maxr = 0;
    for (int i = 0; i < 1500; i++) begin
      if (ref_code > maxr) maxr = ref_code;
      @(negedge clk);
    end
    chk(maxr == 200, "R5 clamp to external", maxr, 200);
    ref_sel_ext = 0;
  endtask

  task automatic t_disable();
    int n;
    to_done();
    en = 0; repeat (2) @(negedge clk);
    chk(!ss_done, "R7 done clears on disable", ss_done, 0);
    chk(!gate_en && ref_code == 0, "R8 drivers off on disable", {gate_en, ref_code}, 0);
    en = 1; meas(2, 0, 20, n);
    meas(1, 0, 2100, n); near("R8 ramp restarts from zero", n, 2000);
  endtask

  task automatic t_supply_loss();
    int n;
    to_done();
    sup_drv_ok = 0; repeat (2) @(negedge clk);
    chk(!ss_done && !gate_en, "R7 done clears on supply loss", {ss_done, gate_en}, 0);
    sup_drv_ok = 1;
    meas(2, 0, 20, n);
    meas(1, 0, 2100, n); near("R2 ramp after supply returns", n, 2000);
  endtask

  task automatic t_oc_top();
    int n;
    to_done();
    pulse_oc(); @(negedge clk);
    chk(!ss_done && !gate_en && ref_code == 0, "R7 R9 fault drops outputs", {ss_done, gate_en}, 0);
    meas(2, 0, 4000, n); near("R9 discharge then restart", n + 2, 2000);
    pulse_oc();
    meas(2, 0, 6000, n); near("R13 hiccup repeat period", n + 1, 4000);
  endtask

  task automatic t_oc_mid();
    int n;
    fresh_start();
    repeat (1000) @(negedge clk);
    pulse_oc();
    chk(!gate_en, "R10 drivers off mid ramp", gate_en, 0);
    meas(2, 0, 5000, n); near("R10 charge before discharge", n + 1, 3000);
  endtask

  task automatic t_oc_ignore();
    int n;
    to_done();
    pulse_oc();
    repeat (500) @(negedge clk);
    pulse_oc();
    meas(2, 0, 4000, n); near("R11 repeat event ignored", n + 502, 2000);
  endtask

  task automatic t_dis_priority();
    int n;
    to_done();
    pulse_oc();
    repeat (500) @(negedge clk);
    en = 0; repeat (10) @(negedge clk);
    chk(!gate_en && ref_code == 0, "R12 disable in fault", gate_en, 0);
    en = 1; meas(2, 0, 4000, n);
    chk(n < 8, "R12 immediate restart after disable", n, 3);
    meas(1, 0, 2100, n); near("R12 full ramp after disable", n, 2000);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_supply();
    t_ramp_int();
    t_ramp_ext();
    t_disable();
    t_supply_loss();
    t_oc_top();
    t_oc_mid();
    t_oc_ignore();
    t_dis_priority();
    summary();
    $finish;
  end
endmodule